// File: doc/BRIEF.md
# Key Matrix Scanner with Debounce

This block reads a grid of push keys wired between six scan lines and five return lines. It raises one scan line at a time, in a fixed order. Near the end of that line's time slot it samples the five return lines. After a full sweep of all six lines it has a 30-bit snapshot of the keys. A snapshot is accepted only if it equals the snapshot from the sweep just before it. An accepted snapshot is copied to a result register that the host reads.

When an accepted result holds at least one pressed key and differs from the result already stored, a ready flag goes high. The host can poll this flag or use it as an interrupt. The host pulses a read-done input after it has shifted the 30 bits out, and this clears the flag. When all keys are released and two empty sweeps agree, the result returns to zero and the flag drops.

In sleep mode the sequencer stops. The scan lines then carry fixed levels chosen by software, so that a key press can still pull a return line. The length of a sweep is a parameter. Its default is 2304 clocks, and each line gets an equal slot.

Top module: `kmsKeyScanner`

## Requirements
- R1: While reset is high at a clock edge, after that edge every scan output is 0, the key result is all zeros and the ready flag is 0.
- R2: Outside reset and sleep, exactly one scan output is 1 at a time. Line 0 is active for the first SLOT = PERIOD/NUM_SCAN clocks after reset, then line 1, and so on up to line NUM_SCAN-1, after which line 0 follows again. One sweep lasts PERIOD clocks.
- R3: A key joining scan line j to return line i is reported in result bit j*NUM_RET + i, where a return line reads 1 when its key is pressed.
- R4: The result changes only at the last clock of a sweep, and only when that sweep's snapshot equals the previous sweep's snapshot. When a key is held from reset, the ready flag rises at the edge that ends the second sweep (edge 2*PERIOD counted from the first edge after reset, which is edge 0) and not before.
- R5: A key pattern that appears in a single sweep only is never reported.
- R6: The ready flag is set by an accepted non-zero result that differs from the stored one. A read-done pulse clears it, and it stays clear while the same keys stay held.
- R7: When two consecutive sweeps see no key, the result becomes all zeros and the ready flag goes to 0.
- R8: While sleep is high, scan output k equals sleep level bit k, and the result and ready flag do not change. When sleep is released, scanning restarts at line 0.
- R9: If a read-done pulse falls on the same edge that sets the ready flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| sleepEn | input | 1 | Sleep mode: stop scanning and drive fixed levels |
| sleepLevels | input | NUM_SCAN | Scan line levels used in sleep mode |
| readDone | input | 1 | One-clock pulse when the host has read the result |
| retIn | input | NUM_RET | Return lines, 1 = key pressed on the active scan line |
| scanOut | output | NUM_SCAN | Scan lines, active high |
| keyData | output | NUM_SCAN*NUM_RET | Accepted key result |
| keyReady | output | 1 | Key data ready flag |

## Verification
The host's read-done pulse and an accepted new result can land on the same clock edge. If they do, one clears the ready flag and the other sets it. The bench counts edges from reset release with a key held, and places read-done exactly on the edge that ends the second sweep. It then expects the flag to be high. A design that lets the clear win would lose a key event, and this check would catch it.

// File: rtl/kmsPkg.sv
package kmsPkg;
  // Strobes from the scan sequencer to the key datapath
  typedef struct packed {
    logic sample;   // last clock of a line slot: capture return lines
    logic scanEnd;  // last clock of the last line slot: sweep complete
  } scanStrobeT;
endpackage

// File: rtl/kmsScanCtrl.sv
module kmsScanCtrl
  import kmsPkg::*;
#(
  parameter int NUM_SCAN = 6,
  parameter int PERIOD   = 2304,
  localparam int SLOT    = PERIOD / NUM_SCAN,
  localparam int CNT_W   = (SLOT > 1) ? $clog2(SLOT) : 1,
  localparam int LINE_W  = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleepEn,
  input  logic [NUM_SCAN-1:0] sleepLevels,
  output logic [NUM_SCAN-1:0] scanOut,
  output scanStrobeT          strobe,
  output logic [LINE_W-1:0]   lineIdx
);
  logic             running;
  logic [CNT_W-1:0] slotCnt;
  logic             slotEnd;
  logic             lastLine;

  assign lastLine = (lineIdx == LINE_W'(NUM_SCAN - 1));
  assign slotEnd  = running && !sleepEn && (slotCnt == CNT_W'(SLOT - 1));
  assign strobe.sample  = slotEnd;
  assign strobe.scanEnd = slotEnd && lastLine;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      slotCnt <= '0;
      lineIdx <= '0;
    end else begin
      running <= 1'b1;
      if (!running || sleepEn) begin
        slotCnt <= '0;
        lineIdx <= '0;
      end else if (slotEnd) begin
        slotCnt <= '0;
        lineIdx <= lastLine ? '0 : lineIdx + LINE_W'(1);
      end else begin
        slotCnt <= slotCnt + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_SCAN; g++) begin : gScanLine
    assign scanOut[g] = !running ? 1'b0
                      : sleepEn  ? sleepLevels[g]
                      : (lineIdx == LINE_W'(g));
  end

  AST_SCAN_LOW_IN_RESET: assert property (@(posedge clk)
    rst |=> (scanOut == '0)); // R1
  AST_ONE_LINE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (running && !sleepEn) |-> ($countones(scanOut) == 1)); // R2
  AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
    strobe.scanEnd |=> (sleepEn || scanOut[0])); // R2
endmodule

// File: rtl/kmsKeyData.sv
module kmsKeyData
  import kmsPkg::*;
#(
  parameter int NUM_SCAN = 6,
  parameter int NUM_RET  = 5,
  localparam int KEYS    = NUM_SCAN * NUM_RET,
  localparam int LINE_W  = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  scanStrobeT         strobe,
  input  logic [LINE_W-1:0]  lineIdx,
  input  logic [NUM_RET-1:0] retIn,
  input  logic               readDone,
  output logic [KEYS-1:0]    keyData,
  output logic               keyReady
);
  logic [KEYS-1:0] scanBuf;
  logic [KEYS-1:0] prevScan;
  logic [KEYS-1:0] curScan;

  // Snapshot so far, with the active line's slice replaced by the live sample
  always_comb begin
    curScan = scanBuf;
    for (int s = 0; s < NUM_SCAN; s++) begin
      if (lineIdx == LINE_W'(s)) curScan[s*NUM_RET +: NUM_RET] = retIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanBuf  <= '0;
      prevScan <= '0;
      keyData  <= '0;
      keyReady <= 1'b0;
    end else begin
      if (readDone) keyReady <= 1'b0;
      if (strobe.sample) scanBuf <= curScan;
      if (strobe.scanEnd) begin
        prevScan <= curScan;
        if (curScan == prevScan) begin
          if (curScan == '0) begin
            keyData  <= '0;
            keyReady <= 1'b0;
          end else if (curScan != keyData) begin
            keyData  <= curScan;
            keyReady <= 1'b1;  // overrides a coincident read-done
          end
        end
      end
    end
  end

  AST_DATA_CLEAR_IN_RESET: assert property (@(posedge clk)
    rst |=> (keyData == '0 && !keyReady)); // R1
  AST_DATA_ONLY_AT_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
    !strobe.scanEnd |=> $stable(keyData)); // R4
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (readDone && !strobe.scanEnd) |=> !keyReady); // R6
  AST_READY_IMPLIES_KEYS: assert property (@(posedge clk) disable iff (rst)
    keyReady |-> (keyData != '0)); // R7
endmodule

// File: rtl/kmsKeyScanner.sv
module kmsKeyScanner
  import kmsPkg::*;
#(
  parameter int NUM_SCAN = 6,
  parameter int NUM_RET  = 5,
  parameter int PERIOD   = 2304
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sleepEn,
  input  logic [NUM_SCAN-1:0]          sleepLevels,
  input  logic                         readDone,
  input  logic [NUM_RET-1:0]           retIn,
  output logic [NUM_SCAN-1:0]          scanOut,
  output logic [NUM_SCAN*NUM_RET-1:0]  keyData,
  output logic                         keyReady
);
  localparam int LINE_W = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1;

  scanStrobeT        strobe;
  logic [LINE_W-1:0] lineIdx;

  kmsScanCtrl #(.NUM_SCAN(NUM_SCAN), .PERIOD(PERIOD)) uCtrl (
    .clk(clk), .rst(rst), .sleepEn(sleepEn), .sleepLevels(sleepLevels),
    .scanOut(scanOut), .strobe(strobe), .lineIdx(lineIdx)
  );

  kmsKeyData #(.NUM_SCAN(NUM_SCAN), .NUM_RET(NUM_RET)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .lineIdx(lineIdx), .retIn(retIn),
    .readDone(readDone), .keyData(keyData), .keyReady(keyReady)
  );

  AST_SLEEP_FREEZES_DATA: assert property (@(posedge clk) disable iff (rst)
    sleepEn |=> ($stable(keyData) && !$rose(keyReady))); // R8
endmodule

// File: tb/tb_kmsKeyScanner.sv
module tb_kmsKeyScanner;
  localparam int NS   = 6;
  localparam int NR   = 5;
  localparam int P    = 24;
  localparam int SLOT = P / NS;
  localparam int NK   = NS * NR;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleepEn = 1'b0;
  logic [NS-1:0] sleepLevels = '0;
  logic          readDone = 1'b0;
  logic [NR-1:0] retIn;
  logic [NS-1:0] scanOut;
  logic [NK-1:0] keyData;
  logic          keyReady;
  logic [NK-1:0] keys = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  kmsKeyScanner #(.NUM_SCAN(NS), .NUM_RET(NR), .PERIOD(P)) dut (
    .clk(clk), .rst(rst), .sleepEn(sleepEn), .sleepLevels(sleepLevels),
    .readDone(readDone), .retIn(retIn), .scanOut(scanOut),
    .keyData(keyData), .keyReady(keyReady)
  );

  // Key matrix model: a pressed key ties its scan line to its return line
  always_comb begin
    for (int i = 0; i < NR; i++) begin
      retIn[i] = 1'b0;
      for (int j = 0; j < NS; j++)
        if (scanOut[j] && keys[j*NR + i]) retIn[i] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Leaves time just after edge 0 (the first edge with reset low)
  task automatic doReset();
    rst = 1'b1;
    waitEdges(2);
    check(scanOut == '0, "R1 scanOut", 64'(scanOut), 0);
    check(keyData == '0, "R1 keyData", 64'(keyData), 0);
    check(!keyReady,     "R1 keyReady", 64'(keyReady), 0);
    rst = 1'b0;
    waitEdges(1);
  endtask

  task automatic pulseRead();
    readDone = 1'b1;
    waitEdges(1);
    readDone = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [NK-1:0] KA = 30'h0000_0421;
  localparam logic [NK-1:0] KB = 30'h2100_8004;
  localparam logic [NK-1:0] KC = 30'h1040_0300;

  initial begin
    // R1 and R2: reset state and scan sequencing
    keys = '0;
    doReset();
    for (int j = 0; j < NS; j++) begin
      for (int c = 0; c < SLOT; c++) begin
        check(scanOut == NS'(1 << j), "R2 active line", 64'(scanOut), 64'(1 << j));
        waitEdges(1);
      end
    end
    check(scanOut == NS'(1), "R2 wrap to line 0", 64'(scanOut), 1);

    // R4: with keys held from reset, ready rises exactly at edge 2P
    keys = KA;
    doReset();
    waitEdges(2*P - 1);
    check(!keyReady,     "R4 ready before 2nd sweep end", 64'(keyReady), 0);
    check(keyData == '0, "R4 data before 2nd sweep end", 64'(keyData), 0);
    waitEdges(1);
    check(keyReady,      "R4 ready at 2nd sweep end", 64'(keyReady), 1);
    check(keyData == KA, "R4 data at 2nd sweep end", 64'(keyData), 64'(KA));

    // R9: read-done on the very edge that sets ready (also re-checks R1 clear)
    keys = KB;
    doReset();
    waitEdges(2*P - 1);
    readDone = 1'b1;
    waitEdges(1);
    readDone = 1'b0;
    check(keyReady, "R9 set wins over read-done", 64'(keyReady), 1);
    check(keyData == KB, "R9 data", 64'(keyData), 64'(KB));

    // R6: read-done clears, and a held key does not set it again
    pulseRead();
    check(!keyReady, "R6 cleared by read", 64'(keyReady), 0);
    waitEdges(3*P);
    check(!keyReady, "R6 stays clear while held", 64'(keyReady), 0);
    check(keyData == KB, "R6 data kept", 64'(keyData), 64'(KB));

    // R5: a pattern seen in one sweep only (sweep 2) is not reported
    keys = '0;
    doReset();
    waitEdges(P);
    keys = KC;
    waitEdges(P);
    keys = '0;
    check(keyData == '0 && !keyReady, "R5 single-sweep glitch", 64'(keyData), 0);
    waitEdges(2*P);
    check(keyData == '0 && !keyReady, "R5 glitch later", 64'(keyData), 0);

    // R3: every single key lands in bit j*NR+i
    for (int k = 0; k < NK; k++) begin
      keys = NK'(1) << k;
      waitEdges(3*P + 2);
      check(keyData == (NK'(1) << k), "R3 key position", 64'(keyData), 64'(NK'(1) << k));
      check(keyReady, "R6 ready on new key", 64'(keyReady), 1);
      pulseRead();
      check(!keyReady, "R6 cleared by read", 64'(keyReady), 0);
    end

    // R3: multi-key patterns
    for (int m = 0; m < 3; m++) begin
      logic [NK-1:0] pat;
      pat = (m == 0) ? {NK{1'b1}} : (m == 1) ? 30'h2AAA_AAAA : 30'h1555_5555;
      keys = pat;
      waitEdges(3*P + 2);
      check(keyData == pat, "R3 multi-key pattern", 64'(keyData), 64'(pat));
    end

    // R7: release everything without reading; data and ready both clear
    keys = KA;
    waitEdges(3*P + 2);
    check(keyReady, "R7 ready before release", 64'(keyReady), 1);
    keys = '0;
    waitEdges(3*P + 2);
    check(keyData == '0, "R7 data cleared", 64'(keyData), 0);
    check(!keyReady, "R7 ready cleared", 64'(keyReady), 0);

    // R8: sleep levels, frozen data, restart at line 0
    keys = KA;
    waitEdges(3*P + 2);
    sleepEn = 1'b1;
    sleepLevels = 6'b101100;
    #1;
    check(scanOut == 6'b101100, "R8 sleep levels", 64'(scanOut), 64'h2c);
    keys = KC;
    waitEdges(4*P);
    check(keyData == KA, "R8 data frozen in sleep", 64'(keyData), 64'(KA));
    check(keyReady, "R8 ready frozen in sleep", 64'(keyReady), 1);
    sleepLevels = 6'b010011;
    #1;
    check(scanOut == 6'b010011, "R8 sleep levels follow", 64'(scanOut), 64'h13);
    sleepEn = 1'b0;
    #1;
    check(scanOut == NS'(1), "R8 restart at line 0", 64'(scanOut), 1);
    waitEdges(3*P + 2);
    check(keyData == KC, "R8 scanning resumes", 64'(keyData), 64'(KC));

    // R1: reset from a loaded state
    rst = 1'b1;
    waitEdges(1);
    check(scanOut == '0 && keyData == '0 && !keyReady, "R1 reset clears",
          64'(keyData), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule